// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Byte-Lane SRAM

This block is a synchronous static memory with four byte lanes and a small, parameterized depth. Reads and writes share one address and control port. A write command is registered on its own edge, and its data is taken off the write-data bus some clock-enabled edges later. That delay is chosen so that write data trails its command by the same number of cycles as read data trails a read. A host can therefore alternate reads and writes on every cycle, and the data bus never needs an idle turnaround slot.

A parameter selects one of two timings. In pipelined mode the read data passes through an output register, and write data is captured on the second enabled edge after the command. In flow-through mode the read data is driven straight from the array in the cycle after the command, and write data is captured on the first enabled edge after the command. An active-low clock enable freezes the whole block. While it is high, the point at which write data is sampled moves later by the same amount, so each data word still lands with the command that was registered for it.

Top module: `sram_zt`

## Requirements
- R1: An access is accepted only when `sel0_n`, `sel1_n` and `sel2_n` are all low at an enabled edge. If any of them is high, the cycle is a deselect: it does not change memory and produces no read data.
- R2: An access is accepted only when `load_n` is low at an enabled edge. With `load_n` high, the cycle does not change memory and produces no read data, whatever `wr_n` and `lane_wr_n` are.
- R3: A read is `wr_n` high at an accepting edge. In pipelined mode (`PIPELINED`=1) the word appears on `rdata` with `rvalid` high just after the next enabled edge. In flow-through mode (`PIPELINED`=0) it appears just after the command edge itself. Either way it is held until the following enabled edge.
- R4: A write is `wr_n` low at an accepting edge. Its data is taken from `wdata` at the second later enabled edge in pipelined mode, or at the first later enabled edge in flow-through mode.
- R5: `lane_wr_n[i]` is active low and governs bits `8*i+7 : 8*i` of the word. Lanes whose enable is high keep their previous contents.
- R6: A write with all four `lane_wr_n` bits high is a no-operation. It leaves memory unchanged and `rvalid` low.
- R7: In pipelined mode, a read of an address whose write data is being captured on the same edge that latches the read word returns the new bytes for the enabled lanes and the array bytes for the rest.
- R8: `rvalid` is high only in cycles that carry read data. `rdata` is zero whenever `rvalid` is low.
- R9: While `clk_en_n` is high at an edge, that edge is ignored. Nothing changes: outputs, pending commands, memory and the write-data sampling point all stay as they were, and the command inputs are not looked at.
- R10: A synchronous `rst` clears `rvalid` and `rdata` and discards pending commands. A write whose data had not yet been captured never reaches memory.
- R11: Reads and writes may be issued on consecutive cycles in any order without idle cycles, and each read returns the contents that every earlier write leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel0_n | input | 1 | Active-low select, first of three |
| sel1_n | input | 1 | Active-low select, second of three |
| sel2_n | input | 1 | Active-low select, third of three |
| wr_n | input | 1 | Low for write, high for read |
| load_n | input | 1 | Active-low command load strobe |
| lane_wr_n | input | LANES | Active-low per-byte write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled late |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | High when `rdata` carries a read result |

## Verification
The bench drives a pipelined and a flow-through instance with the same inputs, so the same `wdata` word belongs to a different command in each. If the late-write delay were off by one cycle in either mode, the wrong word would be stored and a later readback would catch it. A read placed right behind a write to the same address, with only some lanes enabled, targets the forwarding path: without it the read returns the stale word, and with a wrong byte mask it returns the wrong mix. Clock-enable stalls are inserted between a write command and its data edge while a conflicting command is held on the pins. A design that kept counting through the stall, or that obeyed the pins during it, would capture the wrong data or perform an extra write. A reset placed between a write command and its data edge catches a design that lets the orphaned write land.

// File: rtl/sram_zt_pkg.sv
package sram_zt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Turn the sampled control pins into a command kind.
    function automatic op_e classify(input logic selected,
                                     input logic load_n,
                                     input logic wr_n,
                                     input logic any_lane);
        if (!selected || load_n) return OP_IDLE;
        if (wr_n)                return OP_READ;
        if (any_lane)            return OP_WRITE;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/sram_zt_decode.sv
module sram_zt_decode
    import sram_zt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4
) (
    input  logic [2:0]        sel_n,
    input  logic              wr_n,
    input  logic              load_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_lanes
);
    logic selected;
    logic any_lane;

    always_comb begin
        selected  = (sel_n == 3'b000);
        any_lane  = ~&lane_wr_n;
        cmd_op    = classify(selected, load_n, wr_n, any_lane);
        cmd_addr  = addr;
        cmd_lanes = (cmd_op == OP_WRITE) ? ~lane_wr_n : '0;
    end
endmodule

// File: rtl/sram_zt_array.sv
module sram_zt_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end
endmodule

// File: rtl/sram_zt_ctrl.sv
module sram_zt_ctrl
    import sram_zt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en_n,
    input  op_e                      new_op,
    input  logic [ADDR_W-1:0]        new_addr,
    input  logic [LANES-1:0]         new_lanes,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES*LANE_W-1:0]  arr_rdata,
    output logic                     arr_we,
    output logic [ADDR_W-1:0]        arr_waddr,
    output logic [LANES-1:0]         arr_lanes,
    output logic [LANES*LANE_W-1:0]  arr_wdata,
    output logic [ADDR_W-1:0]        arr_raddr,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } cmd_t;

    localparam cmd_t CMD_NONE = '{op: OP_IDLE, addr: '0, lanes: '0};

    logic advance;
    cmd_t a_q;

    assign advance = ~clk_en_n;

    // First stage: the command registered on its own edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= CMD_NONE;
        end else if (advance) begin
            a_q <= '{op: new_op, addr: new_addr, lanes: new_lanes};
        end
    end

    assign arr_raddr = a_q.addr;
    assign arr_wdata = wdata;

    if (PIPELINED) begin : g_pipe
        cmd_t              b_q;
        logic              hit;
        logic [DATA_W-1:0] merged;
        logic [DATA_W-1:0] q_data;
        logic              q_valid;

        always_ff @(posedge clk) begin
            if (rst) begin
                b_q <= CMD_NONE;
            end else if (advance) begin
                b_q <= a_q;
            end
        end

        assign arr_we    = advance && !rst && (b_q.op == OP_WRITE);
        assign arr_waddr = b_q.addr;
        assign arr_lanes = b_q.lanes;

        assign hit = (b_q.op == OP_WRITE) && (b_q.addr == a_q.addr);

        for (genvar g = 0; g < LANES; g++) begin : g_fwd
            assign merged[g*LANE_W +: LANE_W] = (hit && b_q.lanes[g])
                ? wdata[g*LANE_W +: LANE_W]
                : arr_rdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q_valid <= 1'b0;
                q_data  <= '0;
            end else if (advance) begin
                q_valid <= (a_q.op == OP_READ);
                q_data  <= (a_q.op == OP_READ) ? merged : '0;
            end
        end

        assign rdata  = q_data;
        assign rvalid = q_valid;

        assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
            (advance && a_q.op == OP_READ) |=> rvalid);

        assert_no_valid_on_nonread_R8: assert property (@(posedge clk) disable iff (rst)
            (advance && a_q.op != OP_READ) |=> (!rvalid && rdata == '0));

        assert_forward_lane0_R7: assert property (@(posedge clk) disable iff (rst)
            (advance && a_q.op == OP_READ && hit && b_q.lanes[0])
            |=> (rdata[LANE_W-1:0] == $past(wdata[LANE_W-1:0])));

        assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
            clk_en_n |=> ($stable(rdata) && $stable(rvalid)));
    end else begin : g_flow
        assign arr_we    = advance && !rst && (a_q.op == OP_WRITE);
        assign arr_waddr = a_q.addr;
        assign arr_lanes = a_q.lanes;
        assign rvalid    = (a_q.op == OP_READ);
        assign rdata     = rvalid ? arr_rdata : '0;

        assert_flow_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
            clk_en_n |=> $stable(rvalid));
    end

    assert_write_has_lane_R6: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (arr_lanes != '0));

    assert_pending_write_dropped_R10: assert property (@(posedge clk)
        rst |-> !arr_we);
endmodule

// File: rtl/sram_zt.sv
module sram_zt
    import sram_zt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en_n,
    input  logic                     sel0_n,
    input  logic                     sel1_n,
    input  logic                     sel2_n,
    input  logic                     wr_n,
    input  logic                     load_n,
    input  logic [LANES-1:0]         lane_wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_lanes;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [LANES-1:0]  arr_lanes;
    logic [DATA_W-1:0] arr_wdata;
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_rdata;

    sram_zt_decode #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) decode_i (
        .sel_n     ({sel2_n, sel1_n, sel0_n}),
        .wr_n      (wr_n),
        .load_n    (load_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_lanes (cmd_lanes)
    );

    sram_zt_ctrl #(
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .LANE_W    (LANE_W),
        .PIPELINED (PIPELINED)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .clk_en_n  (clk_en_n),
        .new_op    (cmd_op),
        .new_addr  (cmd_addr),
        .new_lanes (cmd_lanes),
        .wdata     (wdata),
        .arr_rdata (arr_rdata),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_lanes (arr_lanes),
        .arr_wdata (arr_wdata),
        .arr_raddr (arr_raddr),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    sram_zt_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) array_i (
        .clk      (clk),
        .wr_en    (arr_we),
        .wr_addr  (arr_waddr),
        .wr_lanes (arr_lanes),
        .wr_data  (arr_wdata),
        .rd_addr  (arr_raddr),
        .rd_data  (arr_rdata)
    );

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && (sel0_n || sel1_n || sel2_n)) |=> (ctrl_i.a_q.op == OP_IDLE));

    assert_load_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && load_n) |=> (ctrl_i.a_q.op == OP_IDLE));
endmodule

// File: tb/sram_zt_tb_top.sv
module sram_zt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic [2:0]  sel_n = 3'b111;
    logic        wr_n = 1'b1;
    logic        load_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_p, rdata_f;
    logic        rvalid_p, rvalid_f;

    int checks = 0;
    int errors = 0;
    string prev_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_zt #(.PIPELINED(1'b1)) dut_i (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .sel0_n(sel_n[0]), .sel1_n(sel_n[1]), .sel2_n(sel_n[2]),
        .wr_n(wr_n), .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .wdata(wdata), .rdata(rdata_p), .rvalid(rvalid_p));

    sram_zt #(.PIPELINED(1'b0)) dut_ft_i (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .sel0_n(sel_n[0]), .sel1_n(sel_n[1]), .sel2_n(sel_n[2]),
        .wr_n(wr_n), .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .wdata(wdata), .rdata(rdata_f), .rvalid(rvalid_f));

    // Reference model built from the requirements: op 0 idle, 1 read, 2 write.
    logic [31:0] mp [16];
    logic [31:0] mf [16];
    int p1_op = 0, p1_a = 0, p2_op = 0, p2_a = 0, f1_op = 0, f1_a = 0;
    logic [3:0] p1_l = 0, p2_l = 0, f1_l = 0;
    logic po_v = 0;
    logic [31:0] po_d = 0;

    function automatic logic [31:0] mrg(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] lanes);
        logic [31:0] r = old_w;
        for (int i = 0; i < 4; i++) if (lanes[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    initial for (int i = 0; i < 16; i++) begin mp[i] = '0; mf[i] = '0; end

    always @(posedge clk) begin
        int n_op;
        logic [31:0] nd;
        n_op = 0;
        if (sel_n == 3'b000 && !load_n)
            n_op = wr_n ? 1 : ((lane_wr_n != 4'hF) ? 2 : 0);
        if (rst) begin
            p1_op = 0; p2_op = 0; f1_op = 0; po_v = 0; po_d = '0;
        end else if (!clk_en_n) begin
            nd = mp[p1_a];
            if (p2_op == 2 && p2_a == p1_a) nd = mrg(nd, wdata, p2_l);
            if (p2_op == 2) mp[p2_a] = mrg(mp[p2_a], wdata, p2_l);
            po_v = (p1_op == 1);
            po_d = po_v ? nd : '0;
            p2_op = p1_op; p2_a = p1_a; p2_l = p1_l;
            p1_op = n_op; p1_a = int'(addr); p1_l = ~lane_wr_n;
            if (f1_op == 2) mf[f1_a] = mrg(mf[f1_a], wdata, f1_l);
            f1_op = n_op; f1_a = int'(addr); f1_l = ~lane_wr_n;
        end
    end

    task automatic compare(input string tag);
        logic        fv = (f1_op == 1);
        logic [31:0] fd = fv ? mf[f1_a] : '0;
        checks++;
        if (rvalid_p !== po_v || rdata_p !== po_d) begin
            errors++;
            $display("FAIL %s pipelined actual=%b/%h expected=%b/%h", tag, rvalid_p, rdata_p, po_v, po_d);
        end
        checks++;
        if (rvalid_f !== fv || rdata_f !== fd) begin
            errors++;
            $display("FAIL %s flow-through actual=%b/%h expected=%b/%h", tag, rvalid_f, rdata_f, fv, fd);
        end
    endtask

    task automatic step(input string tag, input logic r, input logic cen, input logic [2:0] s,
                        input logic w, input logic ld, input logic [3:0] bw,
                        input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        compare(prev_tag);
        prev_tag = tag;
        rst = r; clk_en_n = cen; sel_n = s; wr_n = w; load_n = ld;
        lane_wr_n = bw; addr = a; wdata = d;
    endtask

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd9:  return "R9";
            4'd11: return "R11";
            default: return "R8";
        endcase
    endfunction

    // tag, clk_en_n, sel_n, wr_n, load_n, lane_wr_n, addr, wdata
    localparam logic [49:0] VEC [NVEC] = '{
        {4'd3, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd3,  32'h1111_1111},
        {4'd3, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd4,  32'h2222_2222},
        {4'd3, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h3333_3333},
        {4'd3, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h4444_4444},
        {4'd11, 1'b0, 3'b000, 1'b0, 1'b0, 4'h0, 4'd5, 32'h5050_5050},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd5, 32'h5151_5151},
        {4'd11, 1'b0, 3'b000, 1'b0, 1'b0, 4'h0, 4'd6, 32'h6060_6060},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd6, 32'h6161_6161},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd5, 32'h6262_6262},
        {4'd11, 1'b0, 3'b000, 1'b0, 1'b0, 4'h0, 4'd7, 32'h7070_7070},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0, 32'h7171_7171},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0, 32'h7272_7272},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd7, 32'h7373_7373},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0, 32'h7474_7474},
        {4'd11, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0, 32'h7575_7575},
        {4'd7, 1'b0, 3'b000, 1'b0, 1'b0, 4'b1100, 4'd8, 32'h8080_8080},
        {4'd7, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd8,  32'h8181_8181},
        {4'd7, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h8282_8282},
        {4'd7, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h8383_8383},
        {4'd5, 1'b0, 3'b000, 1'b0, 1'b0, 4'b1110, 4'd9, 32'h9090_9090},
        {4'd5, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h9191_9191},
        {4'd5, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h9292_9292},
        {4'd5, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd9,  32'h9393_9393},
        {4'd5, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h9494_9494},
        {4'd5, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h9595_9595},
        {4'd6, 1'b0, 3'b000, 1'b0, 1'b0, 4'hF, 4'd10, 32'hA0A0_A0A0},
        {4'd6, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hA1A1_A1A1},
        {4'd6, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hA2A2_A2A2},
        {4'd6, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd10, 32'hA3A3_A3A3},
        {4'd6, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hA4A4_A4A4},
        {4'd6, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hA5A5_A5A5},
        {4'd1, 1'b0, 3'b001, 1'b1, 1'b0, 4'hF, 4'd3,  32'hB0B0_B0B0},
        {4'd1, 1'b0, 3'b010, 1'b0, 1'b0, 4'h0, 4'd3,  32'hB1B1_B1B1},
        {4'd1, 1'b0, 3'b100, 1'b0, 1'b0, 4'h0, 4'd3,  32'hB2B2_B2B2},
        {4'd1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hB3B3_B3B3},
        {4'd1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hB4B4_B4B4},
        {4'd1, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd3,  32'hB5B5_B5B5},
        {4'd1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hB6B6_B6B6},
        {4'd1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hB7B7_B7B7},
        {4'd2, 1'b0, 3'b000, 1'b0, 1'b1, 4'h0, 4'd3,  32'hC0C0_C0C0},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd4,  32'hC1C1_C1C1},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hC2C2_C2C2},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hC3C3_C3C3},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd3,  32'hC4C4_C4C4},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hC5C5_C5C5},
        {4'd2, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hC6C6_C6C6},
        {4'd9, 1'b0, 3'b000, 1'b0, 1'b0, 4'h0, 4'd11, 32'hD0D0_D0D0},
        {4'd9, 1'b1, 3'b000, 1'b0, 1'b0, 4'h0, 4'd12, 32'hD1D1_D1D1},
        {4'd9, 1'b1, 3'b000, 1'b0, 1'b0, 4'h0, 4'd12, 32'hD2D2_D2D2},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hD3D3_D3D3},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hD4D4_D4D4},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd11, 32'hD5D5_D5D5},
        {4'd9, 1'b1, 3'b000, 1'b0, 1'b0, 4'h0, 4'd11, 32'hD6D6_D6D6},
        {4'd9, 1'b1, 3'b000, 1'b0, 1'b0, 4'h0, 4'd11, 32'hD7D7_D7D7},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hD8D8_D8D8},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hD9D9_D9D9},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd12, 32'hE0E0_E0E0},
        {4'd9, 1'b1, 3'b000, 1'b0, 1'b0, 4'h0, 4'd12, 32'hE1E1_E1E1},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hE2E2_E2E2},
        {4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hE3E3_E3E3}
    };

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rvalid_p !== 1'b0 || rdata_p !== '0 || rvalid_f !== 1'b0 || rdata_f !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%b/%h %b/%h expected=0/0", rvalid_p, rdata_p, rvalid_f, rdata_f);
        end
        // R4: fill every word with back-to-back writes
        for (int i = 0; i < 18; i++)
            step("R4", 1'b0, 1'b0, 3'b000, 1'b0, (i < 16) ? 1'b0 : 1'b1, 4'h0,
                 4'(i), 32'hA500_0000 | (32'(i) * 32'h0001_0203));
        for (int i = 0; i < NVEC; i++)
            step(tag_name(VEC[i][49:46]), 1'b0, VEC[i][45], VEC[i][44:42], VEC[i][41],
                 VEC[i][40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:0]);
        // R10: reset between a write command and its data edge
        step("R10", 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 4'h0, 4'd13, 32'hF0F0_F0F0);
        step("R10", 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hDEAD_BEEF);
        step("R10", 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'hDEAD_BEEF);
        step("R10", 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 4'hF, 4'd13, 32'h0);
        step("R10", 1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h0);
        step("R10", 1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h0);
        step("R8",  1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 4'd0,  32'h0);
        @(negedge clk);
        compare(prev_tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule